// File: doc/BRIEF.md
# Hexadecimal Error Code Glyph Renderer

This block paints a 32-bit value as a row of eight hexadecimal characters into a monochrome framebuffer that is organised as bytes, one bit per pixel. The buffer is expected to have been cleared by other logic beforehand. The block only ever adds lit pixels to it, so any image already present around or under the characters is kept.

A one-cycle `start` pulse captures the code. The block then walks the characters from the most significant nibble to the least significant one. For each character it takes every glyph row and splits the row's pixels into the framebuffer bytes they fall in. Each byte that holds at least one lit pixel gets a read followed by a write of the OR-ed value. The glyphs are produced by combinational logic from a seven-segment description, so the block needs no stored font. When the last byte is finished, `done` pulses for one cycle.

The framebuffer side is a plain synchronous memory port with a fixed read latency of one cycle. It has no handshake and no back-pressure. The memory must accept a read or a write in every cycle, and the block never issues both in the same cycle. The control pins `start`, `busy` and `done` are plain levels and pulses.

Top module: `hexcode_glyph_drawer`

## Requirements
- R1: After reset, `busy`, `done`, `fb_rd_en` and `fb_wr_en` are 0. They stay 0 while no start is accepted.
- R2: A `start` seen at a clock edge while `busy` is 0 captures `code`, and `busy` is 1 from the next cycle on. Character k (k = 0 to 7) shows nibble `code[31-4k:28-4k]`, so the leftmost character is bits 31..28 and the rightmost is bits 3..0.
- R3: A `start` seen while `busy` is 1, including the `done` cycle, is ignored. The character sequence, the memory traffic and the end time are unchanged, and `busy` is 0 in the cycle after `done`.
- R4: Glyphs are 18 rows by 9 columns and are built from seven segments. The segment sets are given as 7-bit values with bit0 = top, bit1 = upper right, bit2 = lower right, bit3 = bottom, bit4 = lower left, bit5 = upper left and bit6 = middle. The values for 0..F are 3F 06 5B 4F 66 6D 7D 07 7F 6F 77 7C 39 5E 79 71. The regions are as follows:
  - top: rows 0-1
  - middle: rows 8-9
  - bottom: rows 16-17
  - upper verticals: rows 0-9
  - lower verticals: rows 8-17
  - left verticals: columns 0-1
  - right verticals: columns 7-8
- R5: Character k has its left column at x = 28 + 11k and its top row at y = 116. Pixel (x, y) is bit x mod 8 of byte address y*18 + x/8.
- R6: A byte is updated by a read (`fb_rd_en`) in one cycle and a write (`fb_wr_en`) in the next cycle to the same address. The write data is the read data, returned one cycle after the read, OR-ed with the glyph bits for that byte.
- R7: Work proceeds in slots ordered by character, then glyph row, then the lower byte before the upper byte. Each row spans two bytes. A slot with no lit pixel takes one cycle and makes no access. A slot with lit pixels takes two cycles (read, write).
- R8: `done` is 1 for exactly one cycle, directly after the final cycle of the last slot. `busy` is still 1 in that cycle and 0 in the next.
- R9: Unlit glyph pixels and all bytes outside the lit slots keep their previous contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin drawing; sampled only while idle |
| code | input | 32 | Value to display, captured on an accepted start |
| busy | output | 1 | High from the cycle after an accepted start through the done cycle |
| done | output | 1 | One-cycle pulse when drawing has finished |
| fb_addr | output | 12 | Framebuffer byte address for the current read or write |
| fb_rd_en | output | 1 | Framebuffer read request |
| fb_rd_data | input | 8 | Read data, valid the cycle after `fb_rd_en` |
| fb_wr_en | output | 1 | Framebuffer write request |
| fb_wr_data | output | 8 | Merged byte to write |

## Verification
An accepted start shows up as `busy` and the first slot in the very next cycle. Each read is followed by its write exactly one cycle later, carrying the data the memory returned. `done` comes one cycle after the last slot. The reference model therefore turns each code into a per-cycle list of expected port values: idle slot, read with address, write with address and data, and the done cycle. It takes one entry from that list on every falling edge, a half period after the edge that produced it. Restart attempts are driven in the middle of a run and in the done cycle. The whole framebuffer is compared with the model's image after every job.

// File: rtl/hexr_pkg.sv
package hexr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SCAN,
    ST_MERGE,
    ST_FIN
  } hexr_state_t;

  // Segment set per hex value: bit0 top, bit1 upper right, bit2 lower right,
  // bit3 bottom, bit4 lower left, bit5 upper left, bit6 middle.
  function automatic logic [6:0] seg_code(input logic [3:0] nib);
    case (nib)
      4'h0: return 7'h3F;
      4'h1: return 7'h06;
      4'h2: return 7'h5B;
      4'h3: return 7'h4F;
      4'h4: return 7'h66;
      4'h5: return 7'h6D;
      4'h6: return 7'h7D;
      4'h7: return 7'h07;
      4'h8: return 7'h7F;
      4'h9: return 7'h6F;
      4'hA: return 7'h77;
      4'hB: return 7'h7C;
      4'hC: return 7'h39;
      4'hD: return 7'h5E;
      4'hE: return 7'h79;
      default: return 7'h71;
    endcase
  endfunction

  // Segment strokes are two pixels thick; the middle bar straddles rows/2.
  function automatic logic pixel_on(input logic [6:0] s, input int r, input int c,
                                    input int rows, input int cols);
    int mid;
    logic top, bot, mdl, lft, rgt, upr, lwr;
    mid = rows / 2;
    top = (r < 2);
    bot = (r >= rows - 2);
    mdl = (r == mid - 1) || (r == mid);
    lft = (c < 2);
    rgt = (c >= cols - 2);
    upr = (r <= mid);
    lwr = (r >= mid - 1);
    return (s[0] && top) || (s[1] && rgt && upr) || (s[2] && rgt && lwr) ||
           (s[3] && bot) || (s[4] && lft && lwr) || (s[5] && lft && upr) ||
           (s[6] && mdl);
  endfunction

endpackage

// File: rtl/hexr_glyph_rom.sv
module hexr_glyph_rom #(
  parameter int ROWS = 18,
  parameter int COLS = 9,
  parameter int RW   = 5
) (
  input  logic [3:0]      nibble_i,
  input  logic [RW-1:0]   row_i,
  output logic [COLS-1:0] bits_o
);
  logic [6:0] seg;
  assign seg = hexr_pkg::seg_code(nibble_i);

  for (genvar c = 0; c < COLS; c++) begin : g_col
    assign bits_o[c] = hexr_pkg::pixel_on(seg, int'(row_i), c, ROWS, COLS);
  end
endmodule

// File: rtl/hexr_cursor.sv
module hexr_cursor #(
  parameter int CODE_W     = 32,
  parameter int ROWS       = 18,
  parameter int COLS       = 9,
  parameter int X0         = 28,
  parameter int Y0         = 116,
  parameter int PITCH      = 11,
  parameter int LINE_BYTES = 18,
  parameter int ADDR_W     = 12,
  parameter int RW         = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              step_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [COLS-1:0]   glyph_i,
  output logic [3:0]        nibble_o,
  output logic [RW-1:0]     row_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [7:0]        mask_o,
  output logic              last_o
);
  localparam int DIGITS    = CODE_W / 4;
  localparam int DW        = (DIGITS > 1) ? $clog2(DIGITS) : 1;
  localparam int NBYTES    = (COLS + 7 + 7) / 8;
  localparam int BW        = (NBYTES > 1) ? $clog2(NBYTES) : 1;
  localparam int SPAN_BITS = NBYTES * 8;
  localparam int XW        = $clog2(LINE_BYTES * 8) + 1;
  localparam logic [XW-1:0]     X_START   = XW'(X0);
  localparam logic [ADDR_W-1:0] ROW_START = ADDR_W'(Y0 * LINE_BYTES);

  logic [CODE_W-1:0] code_q;
  logic [DW-1:0]     dig_q;
  logic [RW-1:0]     row_q;
  logic [BW-1:0]     byte_q;
  logic [XW-1:0]     xb_q;
  logic [ADDR_W-1:0] rb_q;

  logic byte_end, row_end;
  assign byte_end = (byte_q == BW'(NBYTES - 1));
  assign row_end  = (row_q == RW'(ROWS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      dig_q  <= '0;
      row_q  <= '0;
      byte_q <= '0;
      xb_q   <= X_START;
      rb_q   <= ROW_START;
    end else if (load_i) begin
      code_q <= code_i;
      dig_q  <= '0;
      row_q  <= '0;
      byte_q <= '0;
      xb_q   <= X_START;
      rb_q   <= ROW_START;
    end else if (step_i) begin
      if (!byte_end) begin
        byte_q <= byte_q + 1'b1;
      end else begin
        byte_q <= '0;
        if (!row_end) begin
          row_q <= row_q + 1'b1;
          rb_q  <= rb_q + ADDR_W'(LINE_BYTES);
        end else begin
          row_q  <= '0;
          rb_q   <= ROW_START;
          dig_q  <= dig_q + 1'b1;
          xb_q   <= xb_q + XW'(PITCH);
          code_q <= code_q << 4;
        end
      end
    end
  end

  logic [SPAN_BITS-1:0] wide, sel;
  assign wide = SPAN_BITS'(glyph_i) << xb_q[2:0];
  assign sel  = wide >> {byte_q, 3'b000};

  assign nibble_o = code_q[CODE_W-1 -: 4];
  assign row_o    = row_q;
  assign mask_o   = sel[7:0];
  assign addr_o   = rb_q + ADDR_W'(xb_q >> 3) + ADDR_W'(byte_q);
  assign last_o   = byte_end && row_end && (dig_q == DW'(DIGITS - 1));
endmodule

// File: rtl/hexr_rmw.sv
module hexr_rmw (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [7:0] mask_i,
  input  logic       last_i,
  input  logic [7:0] rd_data_i,
  output logic       load_o,
  output logic       step_o,
  output logic       rd_en_o,
  output logic       wr_en_o,
  output logic [7:0] wr_data_o,
  output logic       busy_o,
  output logic       done_o
);
  import hexr_pkg::*;

  hexr_state_t state_q, state_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    state_d = state_q;
    load_o  = 1'b0;
    step_o  = 1'b0;
    rd_en_o = 1'b0;
    wr_en_o = 1'b0;
    done_o  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          load_o  = 1'b1;
          state_d = ST_SCAN;
        end
      end
      ST_SCAN: begin
        if (mask_i != 8'h00) begin
          rd_en_o = 1'b1;
          state_d = ST_MERGE;
        end else begin
          step_o  = 1'b1;
          state_d = last_i ? ST_FIN : ST_SCAN;
        end
      end
      ST_MERGE: begin
        wr_en_o = 1'b1;
        step_o  = 1'b1;
        state_d = last_i ? ST_FIN : ST_SCAN;
      end
      default: begin
        done_o  = 1'b1;
        state_d = ST_IDLE;
      end
    endcase
  end

  assign wr_data_o = rd_data_i | mask_i;
  assign busy_o    = (state_q != ST_IDLE);
endmodule

// File: rtl/hexcode_glyph_drawer.sv
module hexcode_glyph_drawer #(
  parameter int CODE_W     = 32,
  parameter int GLYPH_ROWS = 18,
  parameter int GLYPH_COLS = 9,
  parameter int X0         = 28,
  parameter int Y0         = 116,
  parameter int PITCH      = 11,
  parameter int LINE_BYTES = 18,
  parameter int FB_ROWS    = 168,
  localparam int FB_BYTES  = FB_ROWS * LINE_BYTES,
  localparam int ADDR_W    = $clog2(FB_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CODE_W-1:0] code,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] fb_addr,
  output logic              fb_rd_en,
  input  logic [7:0]        fb_rd_data,
  output logic              fb_wr_en,
  output logic [7:0]        fb_wr_data
);
  localparam int RW = $clog2(GLYPH_ROWS);

  logic                  load, step, last;
  logic [3:0]            nibble;
  logic [RW-1:0]         row;
  logic [GLYPH_COLS-1:0] glyph;
  logic [7:0]            mask;

  hexr_glyph_rom #(.ROWS(GLYPH_ROWS), .COLS(GLYPH_COLS), .RW(RW)) u_rom (
    .nibble_i (nibble),
    .row_i    (row),
    .bits_o   (glyph)
  );

  hexr_cursor #(
    .CODE_W(CODE_W), .ROWS(GLYPH_ROWS), .COLS(GLYPH_COLS), .X0(X0), .Y0(Y0),
    .PITCH(PITCH), .LINE_BYTES(LINE_BYTES), .ADDR_W(ADDR_W), .RW(RW)
  ) u_cursor (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load),
    .step_i   (step),
    .code_i   (code),
    .glyph_i  (glyph),
    .nibble_o (nibble),
    .row_o    (row),
    .addr_o   (fb_addr),
    .mask_o   (mask),
    .last_o   (last)
  );

  hexr_rmw u_rmw (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start),
    .mask_i    (mask),
    .last_i    (last),
    .rd_data_i (fb_rd_data),
    .load_o    (load),
    .step_o    (step),
    .rd_en_o   (fb_rd_en),
    .wr_en_o   (fb_wr_en),
    .wr_data_o (fb_wr_data),
    .busy_o    (busy),
    .done_o    (done)
  );
endmodule

// File: rtl/hexcode_glyph_drawer_chk.sv
module hexcode_glyph_drawer_chk #(
  parameter int FB_BYTES = 3024,
  parameter int ADDR_W   = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [ADDR_W-1:0] fb_addr,
  input logic              fb_rd_en,
  input logic [7:0]        fb_rd_data,
  input logic              fb_wr_en,
  input logic [7:0]        fb_wr_data
);
  p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!fb_rd_en && !fb_wr_en && !done));

  p_accept_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  p_busy_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  p_addr_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_rd_en || fb_wr_en) |-> (fb_addr < ADDR_W'(FB_BYTES)));

  p_read_then_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fb_rd_en |=> (fb_wr_en && $stable(fb_addr)));

  p_write_after_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fb_wr_en |-> $past(fb_rd_en));

  p_write_keeps_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fb_wr_en |-> ((fb_wr_data & fb_rd_data) == fb_rd_data));

  p_single_access_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(fb_rd_en && fb_wr_en));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));
endmodule

bind hexcode_glyph_drawer hexcode_glyph_drawer_chk #(
  .FB_BYTES(FB_BYTES), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .fb_addr(fb_addr), .fb_rd_en(fb_rd_en), .fb_rd_data(fb_rd_data),
  .fb_wr_en(fb_wr_en), .fb_wr_data(fb_wr_data)
);

// File: tb/tb_hexcode_glyph_drawer.sv
module tb_hexcode_glyph_drawer;
  localparam int CLK_PERIOD = 10;
  localparam int LB         = 18;
  localparam int FB_BYTES   = 168 * LB;
  localparam int XS         = 28;
  localparam int YS         = 116;
  localparam int PITCH      = 11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] code = '0;
  logic        busy, done, fb_rd_en, fb_wr_en;
  logic [11:0] fb_addr;
  logic [7:0]  fb_rd_data, fb_wr_data;

  logic        tb_we = 1'b0;
  int          tb_a = 0;
  logic [7:0]  tb_d = '0;

  logic [7:0]  fb_mem  [FB_BYTES];
  logic [7:0]  ref_img [FB_BYTES];

  int n_cmp = 0;
  int n_bad = 0;
  int q_kind[$];
  int q_addr[$];
  int q_data[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  hexcode_glyph_drawer dut (
    .clk(clk), .rst_n(rst_n), .start(start), .code(code),
    .busy(busy), .done(done), .fb_addr(fb_addr), .fb_rd_en(fb_rd_en),
    .fb_rd_data(fb_rd_data), .fb_wr_en(fb_wr_en), .fb_wr_data(fb_wr_data)
  );

  // Framebuffer memory: one-cycle read latency, bench-side fill port.
  always @(posedge clk) begin
    if (tb_we) fb_mem[tb_a] <= tb_d;
    if (fb_rd_en) fb_rd_data <= fb_mem[fb_addr];
    if (fb_wr_en) fb_mem[fb_addr] <= fb_wr_data;
  end

  task automatic finish_up();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
    finish_up();
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual=0x%0h expected=0x%0h", tag, $time, act, exp);
    end
  endtask

  // Glyph shape from the seven-segment description of R4.
  function automatic bit ref_pix(input int nib, input int r, input int c);
    int segs;
    bit on;
    case (nib)
      0: segs = 'h3F;  1: segs = 'h06;  2: segs = 'h5B;  3: segs = 'h4F;
      4: segs = 'h66;  5: segs = 'h6D;  6: segs = 'h7D;  7: segs = 'h07;
      8: segs = 'h7F;  9: segs = 'h6F; 10: segs = 'h77; 11: segs = 'h7C;
      12: segs = 'h39; 13: segs = 'h5E; 14: segs = 'h79; default: segs = 'h71;
    endcase
    on = 0;
    if (segs[0] && r <= 1) on = 1;
    if (segs[3] && r >= 16) on = 1;
    if (segs[6] && (r == 8 || r == 9)) on = 1;
    if (c >= 7 && segs[1] && r <= 9) on = 1;
    if (c >= 7 && segs[2] && r >= 8) on = 1;
    if (c <= 1 && segs[5] && r <= 9) on = 1;
    if (c <= 1 && segs[4] && r >= 8) on = 1;
    return on;
  endfunction

  // Per-cycle expectation: 0 empty slot, 1 read, 2 write, 3 done.
  task automatic build(input logic [31:0] c);
    for (int k = 0; k < 8; k++) begin
      int nib = int'((c >> (28 - 4 * k)) & 32'hF);
      int x0  = XS + PITCH * k;
      for (int r = 0; r < 18; r++) begin
        int rowbits = 0;
        for (int col = 0; col < 9; col++)
          if (ref_pix(nib, r, col)) rowbits |= (1 << col);
        for (int h = 0; h < 2; h++) begin
          int m = ((rowbits << (x0 % 8)) >> (8 * h)) & 255;
          int a = (YS + r) * LB + x0 / 8 + h;
          if (m == 0) begin
            q_kind.push_back(0); q_addr.push_back(0); q_data.push_back(0);
          end else begin
            q_kind.push_back(1); q_addr.push_back(a); q_data.push_back(0);
            q_kind.push_back(2); q_addr.push_back(a);
            q_data.push_back(int'(ref_img[a]) | m);
            ref_img[a] = ref_img[a] | 8'(m);
          end
        end
      end
    end
    q_kind.push_back(3); q_addr.push_back(0); q_data.push_back(0);
  endtask

  task automatic check_idle(input string tag);
    chk({tag, " busy"}, int'(busy), 0);
    chk({tag, " done"}, int'(done), 0);
    chk({tag, " rd_en"}, int'(fb_rd_en), 0);
    chk({tag, " wr_en"}, int'(fb_wr_en), 0);
  endtask

  // poke >= 0: drive a rival start at that step and in the done cycle (R3).
  task automatic run_job(input logic [31:0] c, input int poke);
    int idx = 0;
    @(negedge clk);
    start = 1'b1;
    code  = c;
    build(c);
    @(negedge clk);
    start = 1'b0;
    code  = ~c;
    while (q_kind.size() > 0) begin
      int kd = q_kind.pop_front();
      int ad = q_addr.pop_front();
      int dt = q_data.pop_front();
      chk("R2 busy", int'(busy), 1);
      chk("R8 done", int'(done), (kd == 3) ? 1 : 0);
      chk("R7 rd_en", int'(fb_rd_en), (kd == 1) ? 1 : 0);
      chk("R6 wr_en", int'(fb_wr_en), (kd == 2) ? 1 : 0);
      if (kd == 1 || kd == 2) chk("R5 addr", int'(fb_addr), ad);
      if (kd == 2) chk("R4 wr_data", int'(fb_wr_data), dt);
      start = (poke >= 0) && (idx == poke || kd == 3);
      idx++;
      @(negedge clk);
    end
    start = 1'b0;
    check_idle("R3 after done");
    @(negedge clk);
    check_idle("R8 settled");
    for (int i = 0; i < FB_BYTES; i++)
      chk("R9 image", int'(fb_mem[i]), int'(ref_img[i]));
  endtask

  task automatic fill(input int a, input logic [7:0] d);
    tb_we = 1'b1;
    tb_a  = a;
    tb_d  = d;
    ref_img[a] = d;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    for (int i = 0; i < FB_BYTES; i++) fill(i, 8'h00);
    @(negedge clk);
    check_idle("R1 in reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_idle("R1 after reset");

    run_job(32'h0123_4567, -1);
    run_job(32'h89AB_CDEF, 5);

    // Existing content under and beside the characters must survive (R9).
    for (int r = 0; r < 18; r++)
      for (int b = 3; b < 16; b++) fill((YS + r) * LB + b, 8'h24);
    fill(0, 8'hA5);
    fill(FB_BYTES - 1, 8'h5A);
    run_job(32'hFFFF_FFFF, 40);

    for (int i = 0; i < FB_BYTES; i++) fill(i, 8'h00);
    run_job(32'h0000_0000, 0);
    run_job(32'hDEAD_BEEF, 100);

    finish_up();
  end
endmodule